// File: doc/BRIEF.md
# PDM CIC Decimator with Output Scaling

This block turns the one-bit pulse-density stream of a digital microphone into signed multi-bit samples at a lower rate. Each bit, taken on a cycle where the microphone-clock enable is high, is mapped to +1 or -1. It then passes through five cascaded integrators that run at the bit rate and five differentiating comb stages that run once every N accepted bits. N is the programmable decimation ratio.

The filter gain is N to the fifth power, so a programmable signed shift rescales the comb result to the fixed sample width expected by a following FIR stage. A positive setting shifts right arithmetically and a negative setting shifts left. The rescaled value saturates to the output word. Each decimated sample is announced by a one-cycle valid strobe. Whenever the ratio or shift inputs change, the whole filter restarts from zero. Any out-of-range control value is pulled to the nearest legal one.

Top module: `pdm_cic_decim`

## Requirements
- R1: While reset is asserted and right after it, `out_data` is 0 and `out_valid` is 0.
- R2: A bit value of 1 contributes +1 and a bit value of 0 contributes -1. With a constant input, the settled output is +N^5 (all ones) or -N^5 (all zeros) before scaling; for example, N=8 with shift 0 gives +32768 and -32768.
- R3: A periodic zero-mean input whose period divides N settles to 0, for example alternating bits with N=16. A stream that repeats the pattern of three ones then one zero, with N=8 and shift 0, settles to 16384.
- R4: `out_valid` is a single-cycle pulse that appears once per N enabled input cycles. The first pulse after a restart comes in the cycle after the N-th enabled input. Cycles with `pdm_ce` low advance nothing.
- R5: A shift setting s in 0..4 divides by 2^s with arithmetic rounding toward minus infinity. For example, N=31 with s=4 gives +1789321 for all ones and -1789322 for all zeros.
- R6: A shift setting s in -8..-1 multiplies by 2^-s. For example, N=5 with s=-8 gives +800000 and -800000.
- R7: The scaled value saturates to +2097151 and -2097152 (22-bit two's complement). `out_data` changes only together with a valid pulse or when a restart clears it to 0.
- R8: `shift_sel` is a 4-bit two's-complement field. Values 5..7 act as 4, so N=31 with setting 7 gives +1789321.
- R9: A `dec_ratio` below 5 acts as 5. Setting 2 with shift 0 gives 3125, with valid pulses every 5 enabled inputs.
- R10: A cycle in which `dec_ratio` or `shift_sel` differs from its previous value clears all filter state and `out_data` to 0. That cycle's input bit is discarded, and a decimation due in that same cycle produces no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdm_ce | input | 1 | High on cycles where `pdm_bit` holds a new microphone bit |
| pdm_bit | input | 1 | Pulse-density input bit |
| dec_ratio | input | 5 | Decimation ratio N, legal 5..31 |
| shift_sel | input | 4 | Signed right-shift amount, legal -8..+4 |
| out_data | output | 22 | Signed decimated, scaled and saturated sample |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` |

## Verification
The collision that matters is a control change in the very cycle where the sample counter reaches its last count and a decimation would fire. The bench runs a settled stream at N=6 and then feeds exactly five more enabled bits. On the sixth enabled bit it also moves the ratio to 9. The pass condition is that no strobe follows, that `out_data` reads 0 in the next cycle, and that the first new strobe arrives only after nine further enabled bits, which shows the clear won over the decimation.

// File: rtl/pdm_cic_pkg.sv
package pdm_cic_pkg;
    parameter int unsigned CIC_ORDER = 5;
    parameter int unsigned ACC_W     = 26;
    parameter int unsigned OUT_W     = 22;
    parameter int unsigned RATIO_W   = 5;
    parameter int unsigned RATIO_MIN = 5;
    parameter int unsigned SHIFT_W   = 4;
    parameter int          SHIFT_MAX = 4;
    parameter int          SHIFT_MIN = -8;
endpackage

// File: rtl/pdm_cic_integ.sv
module pdm_cic_integ #(
    parameter int unsigned ORDER = pdm_cic_pkg::CIC_ORDER,
    parameter int unsigned ACC_W = pdm_cic_pkg::ACC_W
) (
    input  logic                        pdm_bit,
    input  logic [ORDER-1:0][ACC_W-1:0] acc_q,
    output logic [ORDER-1:0][ACC_W-1:0] acc_d
);
    // +1 / -1 contribution of the incoming bit
    logic [ACC_W-1:0] step_val;
    assign step_val = pdm_bit ? ACC_W'(1) : {ACC_W{1'b1}};

    // Registered chain: each stage adds the previous stage's stored value
    for (genvar k = 0; k < ORDER; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign acc_d[k] = acc_q[k] + step_val;
        end else begin : g_rest
            assign acc_d[k] = acc_q[k] + acc_q[k-1];
        end
    end
endmodule

// File: rtl/pdm_cic_comb.sv
module pdm_cic_comb #(
    parameter int unsigned ORDER = pdm_cic_pkg::CIC_ORDER,
    parameter int unsigned ACC_W = pdm_cic_pkg::ACC_W
) (
    input  logic [ACC_W-1:0]            sample,
    input  logic [ORDER-1:0][ACC_W-1:0] dly_q,
    output logic [ORDER-1:0][ACC_W-1:0] dly_d,
    output logic [ACC_W-1:0]            result
);
    logic [ACC_W-1:0] stage_v;

    always_comb begin
        stage_v = sample;
        for (int k = 0; k < int'(ORDER); k++) begin
            dly_d[k] = stage_v;
            stage_v  = stage_v - dly_q[k];
        end
        result = stage_v;
    end
endmodule

// File: rtl/pdm_cic_scale.sv
module pdm_cic_scale #(
    parameter int unsigned ACC_W   = pdm_cic_pkg::ACC_W,
    parameter int unsigned OUT_W   = pdm_cic_pkg::OUT_W,
    parameter int unsigned SHIFT_W = pdm_cic_pkg::SHIFT_W
) (
    input  logic signed [ACC_W-1:0]   din,
    input  logic signed [SHIFT_W-1:0] shift,
    output logic signed [OUT_W-1:0]   dout
);
    localparam int unsigned EXT_W = ACC_W + (1 << (SHIFT_W - 1));

    localparam logic signed [EXT_W-1:0] POS_LIM =
        {{(EXT_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] NEG_LIM =
        {{(EXT_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [EXT_W-1:0] ext_v;
    logic signed [EXT_W-1:0] wide_v;
    logic        [SHIFT_W-1:0] amt;

    assign ext_v = {{(EXT_W-ACC_W){din[ACC_W-1]}}, din};

    always_comb begin
        if (shift[SHIFT_W-1]) begin
            amt    = -shift;
            wide_v = ext_v <<< amt;
        end else begin
            amt    = shift;
            wide_v = ext_v >>> amt;
        end
    end

    always_comb begin
        if (wide_v > POS_LIM) begin
            dout = {1'b0, {(OUT_W-1){1'b1}}};
        end else if (wide_v < NEG_LIM) begin
            dout = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            dout = wide_v[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/pdm_cic_decim.sv
module pdm_cic_decim #(
    parameter int unsigned ORDER     = pdm_cic_pkg::CIC_ORDER,
    parameter int unsigned ACC_W     = pdm_cic_pkg::ACC_W,
    parameter int unsigned OUT_W     = pdm_cic_pkg::OUT_W,
    parameter int unsigned RATIO_W   = pdm_cic_pkg::RATIO_W,
    parameter int unsigned RATIO_MIN = pdm_cic_pkg::RATIO_MIN,
    parameter int unsigned SHIFT_W   = pdm_cic_pkg::SHIFT_W,
    parameter int          SHIFT_MAX = pdm_cic_pkg::SHIFT_MAX,
    parameter int          SHIFT_MIN = pdm_cic_pkg::SHIFT_MIN
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pdm_ce,
    input  logic                      pdm_bit,
    input  logic [RATIO_W-1:0]        dec_ratio,
    input  logic signed [SHIFT_W-1:0] shift_sel,
    output logic signed [OUT_W-1:0]   out_data,
    output logic                      out_valid
);
    localparam logic [RATIO_W-1:0]        R_LOW  = RATIO_W'(RATIO_MIN);
    localparam logic [RATIO_W-1:0]        R_ONE  = RATIO_W'(1);
    localparam logic signed [SHIFT_W-1:0] SH_HI  = SHIFT_W'(SHIFT_MAX);
    localparam logic signed [SHIFT_W-1:0] SH_LO  = SHIFT_W'(SHIFT_MIN);

    typedef struct packed {
        logic [ORDER-1:0][ACC_W-1:0] integ;
        logic [ORDER-1:0][ACC_W-1:0] dly;
        logic [RATIO_W-1:0]          cnt;
        logic [RATIO_W-1:0]          ratio_seen;
        logic [SHIFT_W-1:0]          shift_seen;
        logic [OUT_W-1:0]            dout;
        logic                        vld;
    } state_t;

    state_t s_d, s_q;

    logic [RATIO_W-1:0]          ratio_eff;
    logic signed [SHIFT_W-1:0]   shift_eff;
    logic [ORDER-1:0][ACC_W-1:0] integ_next;
    logic [ORDER-1:0][ACC_W-1:0] dly_next;
    logic [ACC_W-1:0]            comb_out;
    logic signed [OUT_W-1:0]     scaled;
    logic                        cfg_chg;

    // Legalise control inputs
    always_comb begin
        ratio_eff = (dec_ratio < R_LOW) ? R_LOW : dec_ratio;
        if (shift_sel > SH_HI) begin
            shift_eff = SH_HI;
        end else if (shift_sel < SH_LO) begin
            shift_eff = SH_LO;
        end else begin
            shift_eff = shift_sel;
        end
    end

    pdm_cic_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
        .pdm_bit (pdm_bit),
        .acc_q   (s_q.integ),
        .acc_d   (integ_next)
    );

    pdm_cic_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
        .sample  (s_q.integ[ORDER-1]),
        .dly_q   (s_q.dly),
        .dly_d   (dly_next),
        .result  (comb_out)
    );

    pdm_cic_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT_W(SHIFT_W)) u_scale (
        .din     (comb_out),
        .shift   (shift_eff),
        .dout    (scaled)
    );

    assign cfg_chg = (dec_ratio != s_q.ratio_seen) || (shift_sel != s_q.shift_seen);

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (cfg_chg) begin
            s_d            = '0;
            s_d.ratio_seen = dec_ratio;
            s_d.shift_seen = shift_sel;
        end else if (pdm_ce) begin
            s_d.integ = integ_next;
            if (s_q.cnt == ratio_eff - R_ONE) begin
                s_d.cnt  = '0;
                s_d.dly  = dly_next;
                s_d.dout = scaled;
                s_d.vld  = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + R_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_data  = s_q.dout;
    assign out_valid = s_q.vld;
endmodule

// File: rtl/pdm_cic_decim_chk.sv
module pdm_cic_decim_chk #(
    parameter int unsigned OUT_W     = 22,
    parameter int unsigned RATIO_W   = 5,
    parameter int unsigned RATIO_MIN = 5,
    parameter int unsigned SHIFT_W   = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      pdm_ce,
    input logic [RATIO_W-1:0]        dec_ratio,
    input logic signed [SHIFT_W-1:0] shift_sel,
    input logic signed [OUT_W-1:0]   out_data,
    input logic                      out_valid
);
    localparam logic [RATIO_W-1:0] R_LOW = RATIO_W'(RATIO_MIN);

    logic [RATIO_W-1:0] prev_ratio;
    logic [SHIFT_W-1:0] prev_shift;
    logic [RATIO_W:0]   ce_seen;
    logic [RATIO_W-1:0] prev_eff;
    logic               chg_now;

    assign chg_now  = (dec_ratio != prev_ratio) || (shift_sel != prev_shift);
    assign prev_eff = (prev_ratio < R_LOW) ? R_LOW : prev_ratio;

    // Counts enabled inputs since the last strobe or restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ratio <= '0;
            prev_shift <= '0;
            ce_seen    <= '0;
        end else begin
            prev_ratio <= dec_ratio;
            prev_shift <= shift_sel;
            if (chg_now) begin
                ce_seen <= '0;
            end else if (out_valid) begin
                ce_seen <= {{RATIO_W{1'b0}}, pdm_ce};
            end else if (pdm_ce) begin
                ce_seen <= ce_seen + 1'b1;
            end
        end
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    a_r4_pulse_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(pdm_ce));

    a_r4_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (ce_seen == {1'b0, prev_eff}));

    a_r10_clear_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((dec_ratio != $past(dec_ratio)) || (shift_sel != $past(shift_sel)))
        |=> (!out_valid && out_data == '0));

    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> (out_valid || out_data == '0));
endmodule

bind pdm_cic_decim pdm_cic_decim_chk #(
    .OUT_W(OUT_W), .RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN), .SHIFT_W(SHIFT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pdm_ce(pdm_ce), .dec_ratio(dec_ratio),
    .shift_sel(shift_sel), .out_data(out_data), .out_valid(out_valid)
);

// File: tb/tb_pdm_cic_decim.sv
`timescale 1ns/1ps
module tb_pdm_cic_decim;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               pdm_ce = 1'b0;
    logic               pdm_bit = 1'b0;
    logic [4:0]         dec_ratio = 5'd8;
    logic signed [3:0]  shift_sel = 4'sd0;
    logic signed [21:0] out_data;
    logic               out_valid;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pdm_cic_decim dut (
        .clk(clk), .rst_n(rst_n), .pdm_ce(pdm_ce), .pdm_bit(pdm_bit),
        .dec_ratio(dec_ratio), .shift_sel(shift_sel),
        .out_data(out_data), .out_valid(out_valid)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic pat(input int kind, input int i);
        case (kind)
            0:       return 1'b1;
            1:       return 1'b0;
            2:       return (i % 2) == 0;
            default: return (i % 4) != 3;
        endcase
    endfunction

    function automatic longint sx(input logic signed [21:0] v);
        return longint'(v);
    endfunction

    task automatic configure(input int r, input int s);
        dec_ratio = 5'(r);
        shift_sel = 4'(s);
        pdm_ce    = 1'b0;
        @(negedge clk);
    endtask

    // Drive a pattern until nvalid strobes were seen
    task automatic feed(input int kind, input int gap, input int nvalid,
                        output longint last, output int first_idx,
                        output int period, output int doubles);
        int ce_i = 0;
        int got = 0;
        int prev_idx = -1;
        int i = 0;
        logic prev_v = 1'b0;
        first_idx = -1;
        period = 0;
        doubles = 0;
        last = 0;
        while (got < nvalid) begin
            pdm_ce  = (i % gap) == 0;
            pdm_bit = pat(kind, ce_i);
            if (pdm_ce) ce_i++;
            @(negedge clk);
            if (out_valid) begin
                if (prev_v) doubles++;
                if (first_idx < 0) first_idx = i;
                if (prev_idx >= 0) period = i - prev_idx;
                prev_idx = i;
                got++;
                last = sx(out_data);
            end
            prev_v = out_valid;
            i++;
        end
        pdm_ce = 1'b0;
    endtask

    task automatic settle(input int r, input int s, input int kind,
                          input longint exp, input string req);
        longint last;
        int f, p, d;
        configure(r, s);
        feed(kind, 1, 10, last, f, p, d);
        chk(req, last, exp);
    endtask

    task automatic t_reset;
        chk("R1 data in reset", sx(out_data), 0);
        chk("R1 valid in reset", longint'(out_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 data after reset", sx(out_data), 0);
        chk("R1 valid after reset", longint'(out_valid), 0);
    endtask

    task automatic t_dc;
        settle(8, 0, 0, 32768, "R2 ones N=8");
        settle(8, 0, 1, -32768, "R2 zeros N=8");
    endtask

    task automatic t_patterns;
        settle(16, 0, 2, 0, "R3 alternating N=16");
        settle(8, 0, 3, 16384, "R3 three-of-four N=8");
    endtask

    task automatic t_timing;
        longint last;
        int f, p, d;
        configure(7, 0);
        feed(0, 3, 4, last, f, p, d);
        chk("R4 first strobe index", f, 18);
        chk("R4 strobe period", p, 21);
        chk("R4 single-cycle strobe", d, 0);
    endtask

    task automatic t_right;
        settle(31, 4, 1, -1789322, "R5 zeros N=31 s=4");
        settle(31, 4, 0, 1789321, "R5 ones N=31 s=4");
    endtask

    task automatic t_left;
        settle(5, -8, 0, 800000, "R6 ones N=5 s=-8");
        settle(5, -8, 1, -800000, "R6 zeros N=5 s=-8");
    endtask

    task automatic t_sat;
        settle(31, 0, 0, 2097151, "R7 positive saturation");
        settle(31, 0, 1, -2097152, "R7 negative saturation");
        settle(31, -8, 0, 2097151, "R7 left-shift saturation");
    endtask

    task automatic t_shclamp;
        settle(31, 7, 0, 1789321, "R8 shift 7 acts as 4");
    endtask

    task automatic t_ratioclamp;
        longint last;
        int f, p, d;
        configure(2, 0);
        feed(0, 1, 10, last, f, p, d);
        chk("R9 ratio 2 value", last, 3125);
        chk("R9 ratio 2 period", p, 5);
    endtask

    task automatic t_collision;
        longint last;
        int f, p, d;
        int early = 0;
        configure(6, 0);
        feed(0, 1, 10, last, f, p, d);
        chk("R10 settled before clash", last, 7776);
        for (int k = 0; k < 5; k++) begin
            pdm_ce = 1'b1;
            pdm_bit = 1'b1;
            @(negedge clk);
            if (out_valid) early++;
        end
        chk("R10 no strobe before clash", early, 0);
        pdm_ce = 1'b1;
        dec_ratio = 5'd9;
        @(negedge clk);
        chk("R10 strobe suppressed", longint'(out_valid), 0);
        chk("R10 data cleared", sx(out_data), 0);
        feed(0, 1, 1, last, f, p, d);
        chk("R10 restart count", f, 8);
        // Shift change alone also clears
        feed(0, 1, 9, last, f, p, d);
        shift_sel = 4'sd1;
        pdm_ce = 1'b0;
        @(negedge clk);
        chk("R10 shift change clears", sx(out_data), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_dc();
        t_patterns();
        t_timing();
        t_right();
        t_left();
        t_sat();
        t_shclamp();
        t_ratioclamp();
        t_collision();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule